// File: doc/BRIEF.md
# Receive Byte Ring with Flow-Control Requests

This block stores bytes from a serial receiver in a 256-entry circular store until a consumer takes them. A write pointer marks the next free slot and a read pointer marks the oldest unread byte. A separate occupancy counter gives the number of stored bytes. One slot is always left unused, so equal pointers mean empty and a write pointer one behind the read pointer means full. When full, the store holds 255 bytes.

The block also watches its occupancy and asks an outgoing transmit path to send in-band pause and resume characters to the far end. It asks for a pause (0x13) when the level reaches a programmable upper mark. It asks for a resume (0x11) when the level later falls to a programmable lower mark. The gap between the two marks gives hysteresis. Each request stays raised until the transmit path acknowledges it. A byte that arrives while the store is full is discarded and sets a sticky overflow flag.

Top module: `rx_ring_flow`

## Requirements
- R1: After reset the block shows `empty`=1, `full`=0, `level`=0, `fc_req`=0 and `overflow`=0.
- R2: Bytes leave in the order they arrived. While `empty`=0, `out_byte` shows the oldest stored byte, and a cycle with `take`=1 removes it.
- R3: `empty` is 1 when no bytes are stored. `full` is 1 when 255 bytes are stored, which is one slot short of the 256 entries.
- R4: `level` rises by one for each accepted byte and falls by one for each removed byte. A cycle that both accepts and removes a byte leaves `level` unchanged.
- R5: Suppose no pause is in force and a clock edge brings `level` to `hi_mark` or above. From that edge `fc_req`=1 and `fc_char`=0x13. Only one pause request is raised per episode, however much higher the level climbs.
- R6: Suppose a pause is in force and a clock edge brings `level` to `lo_mark` or below. From that edge `fc_req`=1 and `fc_char`=0x11. A resume is never requested unless a pause came before it.
- R7: `fc_req` stays 1 with the same `fc_char` until a cycle with `fc_ack`=1. After that edge `fc_req` is 0, unless a new level event arrives on the same edge.
- R8: A pause request may still be unacknowledged when the level falls to `lo_mark`. In that case the request stays raised and `fc_char` changes to 0x11.
- R9: A byte offered while `full`=1 is discarded. `overflow` becomes 1 and stays 1 until reset, and the stored bytes and their order do not change.
- R10: `take` while `empty`=1 has no effect. `level` stays 0, and the next byte written is the next byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_byte | input | 8 | Received byte |
| take | input | 1 | Consumer removes the byte on `out_byte` |
| out_byte | output | 8 | Oldest stored byte, valid while `empty`=0 |
| empty | output | 1 | No bytes stored |
| full | output | 1 | 255 bytes stored |
| level | output | 8 | Number of stored bytes |
| hi_mark | input | 8 | Level that triggers a pause request |
| lo_mark | input | 8 | Level that triggers a resume request |
| fc_req | output | 1 | A flow-control character is waiting to be sent |
| fc_char | output | 8 | Character to send: 0x13 pause, 0x11 resume |
| fc_ack | input | 1 | Transmit path has taken the character |
| overflow | output | 1 | Sticky: a byte was dropped while full |

## Verification
The assertions assume that `lo_mark` is below `hi_mark` and that `hi_mark` is below 255. They also assume that both marks stay constant while bytes are stored and a pause may be in force. The bench writes the marks only while reset is held, so every episode sees one fixed pair of marks. When the bench raises `fc_ack`, it does so either for one cycle against a raised request or as a constant level during the full-store test, where it must not keep a request from rising.

// File: rtl/rx_ring_flow.sv
module rx_ring_flow #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [DW-1:0] PAUSE_CH  = 8'h13,
  parameter logic [DW-1:0] RESUME_CH = 8'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic          take,
  output logic [DW-1:0] out_byte,
  output logic          empty,
  output logic          full,
  output logic [AW-1:0] level,
  input  logic [AW-1:0] hi_mark,
  input  logic [AW-1:0] lo_mark,
  output logic          fc_req,
  output logic [DW-1:0] fc_char,
  input  logic          fc_ack,
  output logic          overflow
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, lvl_nx;
  logic          paused, pend, push, pop, rise, drop_lvl;

  assign empty    = (rd_ptr == wr_ptr);
  assign full     = ((wr_ptr + ONE) == rd_ptr);
  assign push     = in_valid & ~full;
  assign pop      = take & ~empty;
  assign out_byte = store[rd_ptr];
  assign lvl_nx   = level + (push ? ONE : '0) - (pop ? ONE : '0);
  assign rise     = ~paused & (lvl_nx >= hi_mark);
  assign drop_lvl = paused & (lvl_nx <= lo_mark);
  assign fc_req   = pend;
  assign fc_char  = paused ? PAUSE_CH : RESUME_CH;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + ONE;
      if (pop)  rd_ptr <= rd_ptr + ONE;
      level <= lvl_nx;
      if (in_valid && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused <= 1'b0;
      pend   <= 1'b0;
    end else if (rise) begin
      paused <= 1'b1;
      pend   <= 1'b1;
    end else if (drop_lvl) begin
      paused <= 1'b0;
      pend   <= 1'b1;
    end else if (fc_ack) begin
      pend   <= 1'b0;
    end
  end

  a_r4_level_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    level == AW'(wr_ptr - rd_ptr));

  a_r3_full_level: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (level == AW'(DEPTH - 1)));

  a_r5_pause_char: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> (fc_req && fc_char == PAUSE_CH && level >= hi_mark));

  a_r6_resume_char: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> (fc_req && fc_char == RESUME_CH && level <= lo_mark));

  a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && !fc_ack) |=> fc_req);

  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> ($stable(wr_ptr) && overflow));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: tb/rx_ring_flow_bench.sv
module rx_ring_flow_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       take = 1'b0;
  logic [7:0] out_byte;
  logic       empty, full;
  logic [7:0] level;
  logic [7:0] hi_mark = 8'd200;
  logic [7:0] lo_mark = 8'd100;
  logic       fc_req;
  logic [7:0] fc_char;
  logic       fc_ack = 1'b0;
  logic       overflow;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_ring_flow u_rx_ring_flow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .take(take), .out_byte(out_byte), .empty(empty), .full(full),
    .level(level), .hi_mark(hi_mark), .lo_mark(lo_mark), .fc_req(fc_req),
    .fc_char(fc_char), .fc_ack(fc_ack), .overflow(overflow)
  );

  // vector: in_valid, in_byte, take, expected level, expected out_byte, expected empty
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'hA1, 1'b0, 8'd1, 8'hA1, 1'b0},
    {1'b1, 8'hB2, 1'b0, 8'd2, 8'hA1, 1'b0},
    {1'b1, 8'hC3, 1'b1, 8'd2, 8'hB2, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'd1, 8'hC3, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'd0, 8'h00, 1'b1},
    {1'b0, 8'h00, 1'b1, 8'd0, 8'h00, 1'b1},
    {1'b1, 8'hD4, 1'b0, 8'd1, 8'hD4, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'd0, 8'h00, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic t, input logic a);
    in_valid = v; in_byte = d; take = t; fc_ack = a;
    @(posedge clk);
    #1;
    in_valid = 1'b0; take = 1'b0; fc_ack = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] hi, input logic [7:0] lo);
    rst_n = 1'b0;
    hi_mark = hi; lo_mark = lo;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic flowchk(input bit req, input logic [7:0] ch, input string tag);
    chk(fc_req == req, tag, fc_req, req);
    if (req) chk(fc_char == ch, tag, fc_char, ch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(8'd200, 8'd100);
    // R1 reset state
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(level == 8'd0, "R1 level", level, 0);
    chk(fc_req == 1'b0, "R1 fc_req", fc_req, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);

    // R2 R4 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][26], VEC[i][25:18], VEC[i][17], 1'b0);
      chk(level == VEC[i][16:9], "R4 level", level, VEC[i][16:9]);
      chk(empty == VEC[i][0], "R10 empty", empty, VEC[i][0]);
      if (!VEC[i][0]) chk(out_byte == VEC[i][8:1], "R2 order", out_byte, VEC[i][8:1]);
    end

    // R5 R6 R7 hysteresis with hi=5 lo=2
    do_reset(8'd5, 8'd2);
    for (int k = 1; k <= 4; k++) begin
      step(1'b1, 8'(k), 1'b0, 1'b0);
      flowchk(1'b0, 8'h00, "R5 below mark");
    end
    step(1'b1, 8'd5, 1'b0, 1'b0);
    flowchk(1'b1, 8'h13, "R5 pause at mark");
    step(1'b1, 8'd6, 1'b0, 1'b0);
    flowchk(1'b1, 8'h13, "R7 held");
    step(1'b0, 8'd0, 1'b0, 1'b1);
    flowchk(1'b0, 8'h00, "R7 ack clears");
    step(1'b1, 8'd7, 1'b0, 1'b0);
    flowchk(1'b0, 8'h00, "R5 once per episode");
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 8'd0, 1'b1, 1'b0);
      flowchk(1'b0, 8'h00, "R6 above low mark");
    end
    step(1'b0, 8'd0, 1'b1, 1'b0);
    chk(level == 8'd2, "R4 level", level, 2);
    flowchk(1'b1, 8'h11, "R6 resume at mark");
    step(1'b0, 8'd0, 1'b0, 1'b0);
    flowchk(1'b1, 8'h11, "R7 resume held");
    step(1'b0, 8'd0, 1'b0, 1'b1);
    flowchk(1'b0, 8'h00, "R7 resume acked");

    // R8 unacknowledged pause replaced by resume
    step(1'b1, 8'd8, 1'b0, 1'b0);
    step(1'b1, 8'd9, 1'b0, 1'b0);
    flowchk(1'b0, 8'h00, "R6 no resume without pause");
    step(1'b1, 8'd10, 1'b0, 1'b0);
    flowchk(1'b1, 8'h13, "R5 second episode");
    step(1'b0, 8'd0, 1'b1, 1'b0);
    step(1'b0, 8'd0, 1'b1, 1'b0);
    flowchk(1'b1, 8'h13, "R8 still pause");
    step(1'b0, 8'd0, 1'b1, 1'b0);
    flowchk(1'b1, 8'h11, "R8 replaced by resume");
    step(1'b0, 8'd0, 1'b0, 1'b1);
    flowchk(1'b0, 8'h00, "R8 acked");

    // R3 R9 full store and drop
    do_reset(8'd250, 8'd10);
    for (int k = 0; k < 255; k++) step(1'b1, 8'(k), 1'b0, 1'b1);
    chk(full == 1'b1, "R3 full", full, 1);
    chk(level == 8'd255, "R3 level", level, 255);
    chk(overflow == 1'b0, "R9 no overflow yet", overflow, 0);
    step(1'b1, 8'hEE, 1'b0, 1'b1);
    chk(overflow == 1'b1, "R9 overflow set", overflow, 1);
    chk(level == 8'd255, "R9 level kept", level, 255);
    for (int k = 0; k < 255; k++) begin
      chk(out_byte == 8'(k), "R9 R2 contents", out_byte, k);
      step(1'b0, 8'd0, 1'b1, 1'b1);
    end
    chk(empty == 1'b1, "R3 empty", empty, 1);
    chk(level == 8'd0, "R4 drained", level, 0);
    chk(overflow == 1'b1, "R9 sticky", overflow, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule